// File: doc/BRIEF.md
# Text-Mode Cursor Shape Generator

This block decides, for each pixel, whether the text cursor is drawn in a character-cell display controller. Software programs two control bytes. The first holds the topmost cursor scanline and a cursor disable bit. The second holds the bottommost cursor scanline and a skew value. Each pixel clock, the display pipeline supplies four inputs: the scanline index inside the current character row, a strobe that marks character-clock boundaries, a flag saying that the current cell is the cursor cell, and a flag selecting text or graphics mode.

The block first forms a cursor enable. The enable is high only when all of these hold: the mode is text, the cursor is not disabled, the cell matches, and the scanline lies in the programmed window. The enable then passes through a short pipeline that advances on the character strobe. The output takes the tap chosen by the skew field, which lets the cursor line up with downstream pipeline delay. In graphics mode the output is held low whatever the registers and the pipeline contain.

The register port is plain address, data and write-enable, with read data returned combinationally for the addressed byte. There is no streaming data path, so no valid/ready handshake and no back-pressure apply. Control pins are sampled every clock.

Top module: `cursor_shape_gen`

## Requirements
- R1: Address 0 is the start byte. Bits 4:0 hold the first cursor scanline and bit 5 is the disable flag. Reading address 0 returns {2'b00, disable, first}, so writing 8'hFF reads back as 8'h3F.
- R2: Address 1 is the end byte. Bits 4:0 hold the last cursor scanline and bits 6:5 hold the skew. Reading address 1 returns {1'b0, skew, last}, so writing 8'hFF reads back as 8'h7F.
- R3: While the disable flag (start byte bit 5) is 1, the enable captured and presented is 0, so the output is 0.
- R4: Scanlines are numbered from 0 at the top. The scanline condition holds when first <= scan_line <= last. When first > last it holds on no scanline.
- R5: With skew value k (end byte bits 6:5, 0 to 3), cursor_on equals the current enable when k = 0. Otherwise it equals the enable captured at the k-th most recent clock edge where char_strobe was high. Clocks with char_strobe low leave the pipeline unchanged.
- R6: While text_mode is 0, cursor_on is 0 in the same cycle, even when the pipeline holds a 1.
- R7: cursor_on is 0 at skew 0 unless cell_match is 1.
- R8: After reset, both bytes read as 8'h00 and every pipeline stage holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control bytes |
| reg_addr | input | 1 | 0 selects the start byte, 1 selects the end byte |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for the addressed byte, reserved bits zero |
| text_mode | input | 1 | 1 for text mode, 0 for graphics mode |
| cell_match | input | 1 | Current cell is the cursor cell |
| scan_line | input | 5 | Scanline index within the character row |
| char_strobe | input | 1 | Character-clock advance pulse |
| cursor_on | output | 1 | Cursor pixel enable |

## Verification
The scanline window is tested in three ways: swept over all 32 lines for an ordinary window, for a one-line window, and for an inverted window. Together these separate inclusive from exclusive bounds and catch a comparator that ignores ordering. For each of the four skew values, a single enabled character is pushed into the pipeline, followed by idle characters. The output must go high after exactly the programmed number of strobes, which tells a wrong tap apart from a stage that fails to shift. Graphics mode is entered while a 1 sits in the pipeline, and clocks without a strobe are checked to leave the output unchanged. These two checks show that forcing the output off and holding the pipeline both happen at the output, not only in the captured enable.

// File: rtl/cursor_shape_pkg.sv
package cursor_shape_pkg;
  localparam int LINE_W  = 5;
  localparam int SKEW_W  = 2;
  localparam int BYTE_W  = 8;
  localparam int SKEW_DEPTH = (1 << SKEW_W) - 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [SKEW_W-1:0] skew_t;

  typedef struct packed {
    logic  off;
    line_t first;
  } start_cfg_t;

  typedef struct packed {
    skew_t skew;
    line_t last;
  } end_cfg_t;
endpackage

// File: rtl/cursor_cfg_regs.sv
module cursor_cfg_regs
  import cursor_shape_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output start_cfg_t        start_cfg,
  output end_cfg_t          end_cfg
);
  localparam int START_BITS = $bits(start_cfg_t);
  localparam int END_BITS   = $bits(end_cfg_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_cfg <= '0;
      end_cfg   <= '0;
    end else if (wr_en) begin
      if (addr == 1'b0) start_cfg <= start_cfg_t'(wr_data[START_BITS-1:0]);
      else              end_cfg   <= end_cfg_t'(wr_data[END_BITS-1:0]);
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == 1'b0) rd_data[START_BITS-1:0] = start_cfg;
    else              rd_data[END_BITS-1:0]   = end_cfg;
  end

  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> (start_cfg == $past(wr_data[START_BITS-1:0]))) else $error("start write"); // R1
  AST_END_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> (end_cfg == $past(wr_data[END_BITS-1:0]))) else $error("end write"); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(start_cfg) && $stable(end_cfg))) else $error("cfg hold"); // R2
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_shape_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  start_cfg_t start_cfg,
  input  end_cfg_t   end_cfg,
  input  line_t      scan_line,
  input  logic       text_mode,
  input  logic       cell_match,
  output logic       enable
);
  logic above_first;
  logic below_last;
  logic in_window;

  always_comb begin
    above_first = (scan_line >= start_cfg.first);
    below_last  = (scan_line <= end_cfg.last);
    in_window   = above_first && below_last;
    enable      = text_mode && !start_cfg.off && cell_match && in_window;
  end

  AST_INVERTED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cfg.first > end_cfg.last) |-> !enable) else $error("inverted window"); // R4
  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    start_cfg.off |-> !enable) else $error("off flag"); // R3
  AST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_match |-> !enable) else $error("match"); // R7
endmodule

// File: rtl/cursor_skew.sv
module cursor_skew
  import cursor_shape_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  en_in,
  input  skew_t skew,
  input  logic  text_mode,
  output logic  out
);
  logic [SKEW_DEPTH-1:0] stage;
  logic [SKEW_DEPTH:0]   taps;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else if (advance) stage[0] <= en_in;
  end

  genvar g;
  generate
    for (g = 1; g < SKEW_DEPTH; g++) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= 1'b0;
        else if (advance) stage[g] <= stage[g-1];
      end
    end
  endgenerate

  always_comb begin
    taps = {stage, en_in};
    out  = taps[skew] && text_mode;
  end

  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(stage)) else $error("pipe hold"); // R5
  AST_GFX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !text_mode |-> !out) else $error("graphics off"); // R6
endmodule

// File: rtl/cursor_shape_gen.sv
module cursor_shape_gen
  import cursor_shape_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_addr,
  input  logic [BYTE_W-1:0] reg_wr_data,
  output logic [BYTE_W-1:0] reg_rd_data,
  input  logic              text_mode,
  input  logic              cell_match,
  input  logic [LINE_W-1:0] scan_line,
  input  logic              char_strobe,
  output logic              cursor_on
);
  start_cfg_t start_cfg;
  end_cfg_t   end_cfg;
  logic       enable;

  cursor_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wr_data   (reg_wr_data),
    .rd_data   (reg_rd_data),
    .start_cfg (start_cfg),
    .end_cfg   (end_cfg)
  );

  cursor_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cfg  (start_cfg),
    .end_cfg    (end_cfg),
    .scan_line  (scan_line),
    .text_mode  (text_mode),
    .cell_match (cell_match),
    .enable     (enable)
  );

  cursor_skew u_skew (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (char_strobe),
    .en_in     (enable),
    .skew      (end_cfg.skew),
    .text_mode (text_mode),
    .out       (cursor_on)
  );

  AST_ZERO_SKEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((end_cfg.skew == '0) && !cell_match) |-> !cursor_on) else $error("skew0 match"); // R7
endmodule

// File: tb/tb_cursor_shape_gen.sv
`timescale 1ns/1ps
module tb_cursor_shape_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       text_mode = 1'b1;
  logic       cell_match = 1'b0;
  logic [4:0] scan_line = '0;
  logic       char_strobe = 1'b0;
  logic       cursor_on;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cursor_shape_gen dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic strobe();
    @(negedge clk);
    char_strobe = 1'b1;
    @(negedge clk);
    char_strobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); check("R8 start byte", d, 8'h00);
    rd(1'b1, d); check("R8 end byte", d, 8'h00);
    cell_match = 1'b1; scan_line = 5'd1;
    #1 check("R8 line1 outside zero window", {7'b0, cursor_on}, 8'h00);
    scan_line = 5'd0;
    #1 check("R8 line0 inside zero window", {7'b0, cursor_on}, 8'h01);
    cell_match = 1'b0;
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(1'b0, 8'hFF); rd(1'b0, d); check("R1 reserved zero", d, 8'h3F);
    wr(1'b1, 8'hFF); rd(1'b1, d); check("R2 reserved zero", d, 8'h7F);
    wr(1'b0, 8'h15); rd(1'b0, d); check("R1 value", d, 8'h15);
    wr(1'b1, 8'h4A); rd(1'b1, d); check("R2 value", d, 8'h4A);
    rd(1'b0, d); check("R1 kept", d, 8'h15);
  endtask

  task automatic sweep(input logic [4:0] f, input logic [4:0] l, input string req);
    int bad = 0;
    wr(1'b0, {3'b000, f});
    wr(1'b1, {3'b000, l});
    cell_match = 1'b1;
    for (int i = 0; i < 32; i++) begin
      logic expv;
      scan_line = 5'(i);
      expv = (i >= f) && (i <= l);
      #1;
      if (cursor_on !== expv) begin
        bad++;
        $display("FAIL %s line=%0d actual=%0b expected=%0b", req, i, cursor_on, expv);
      end
    end
    n_checks++;
    if (bad != 0) n_fail++;
    cell_match = 1'b0;
  endtask

  task automatic t_range();
    sweep(5'd3, 5'd6, "R4 window 3..6");
    sweep(5'd5, 5'd5, "R4 single line");
    sweep(5'd7, 5'd2, "R4 inverted");
    sweep(5'd0, 5'd31, "R4 full");
  endtask

  task automatic t_off_match();
    wr(1'b0, 8'h20); wr(1'b1, 8'h1F);
    cell_match = 1'b1; scan_line = 5'd4;
    #1 check("R3 off flag", {7'b0, cursor_on}, 8'h00);
    wr(1'b0, 8'h00);
    #1 check("R3 off cleared", {7'b0, cursor_on}, 8'h01);
    cell_match = 1'b0;
    #1 check("R7 no match", {7'b0, cursor_on}, 8'h00);
  endtask

  task automatic t_skew(input int k);
    wr(1'b0, 8'h00);
    wr(1'b1, {1'b0, 2'(k), 5'd31});
    scan_line = 5'd2;
    cell_match = 1'b0;
    repeat (3) strobe();
    cell_match = 1'b1;
    #1 check($sformatf("R5 skew%0d before push", k), {7'b0, cursor_on}, {7'b0, k == 0});
    strobe();
    cell_match = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      #1 check($sformatf("R5 skew%0d after %0d", k, i), {7'b0, cursor_on}, {7'b0, i == k});
      if (i == k) begin
        repeat (3) @(negedge clk);
        #1 check($sformatf("R5 skew%0d hold", k), {7'b0, cursor_on}, 8'h01);
      end
      strobe();
    end
  endtask

  task automatic t_gfx();
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h3F);
    scan_line = 5'd0;
    cell_match = 1'b1;
    strobe();
    cell_match = 1'b0;
    #1 check("R6 pipe holds 1", {7'b0, cursor_on}, 8'h01);
    text_mode = 1'b0;
    #1 check("R6 graphics forced off", {7'b0, cursor_on}, 8'h00);
    repeat (2) @(negedge clk);
    text_mode = 1'b1;
    #1 check("R6 text restored", {7'b0, cursor_on}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_range();
    t_off_match();
    for (int k = 0; k < 4; k++) t_skew(k);
    t_gfx();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule